// File: doc/BRIEF.md
# Round-Robin Bus Arbiter

This block decides which of three initiators owns a shared, multiplexed parallel bus with PCI-style control lines. Each initiator has an active-low request line and gets an active-low grant line back. The requests are sampled on every rising clock edge. The waiting initiators are ranked by a rotating priority pointer, and the winner receives the only grant that is low.

A grant is issued only when the bus is idle, meaning both the cycle-framing line and the initiator-ready line are high. Once the granted initiator starts a transaction by pulling the framing line low, it keeps the grant until the last data phase completes. This holds however many data phases the transaction has, and whether the target or the initiator stretches any phase with wait states. Starting a transaction moves the owner to the bottom of the priority order.

If a granted initiator withdraws its request before it starts, the grant is taken back and arbitration runs again. In that case the priority order is left untouched.

Top module: `rrarb_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, all grant outputs are high.
- R2: Request and grant bit 0 belong to initiator A, bit 1 to B and bit 2 to C. After reset the ranking is B, then C, then A, so simultaneous requests from all three grant B first.
- R3: A grant goes low one clock after an edge that samples a pending request while both `frame_n` and `irdy_n` are high. No grant is issued on an edge where either line is low.
- R4: At most one grant is low at any time. A change of owner always passes through at least one cycle with all grants high.
- R5: Once the owner has driven `frame_n` low, its grant stays low for the whole transaction. This includes several data phases, wait states from either side (`irdy_n` or `trdy_n` held high), and the owner's request going high after the start.
- R6: A transaction ends on an edge that samples `frame_n` high with `irdy_n` and `trdy_n` both low. The grant is high after that edge, and arbitration resumes on the following edge.
- R7: The edge on which a granted initiator is sampled with `frame_n` low makes the next initiator in the order A→B→C→A the highest priority. The owner itself becomes the lowest.
- R8: If the granted initiator's request is high on an edge where `frame_n` is still high, its grant is high after that edge, and the priority order is not changed.
- R9: With no request pending, all grants stay high and the priority order is kept for later arbitration.
- R10: A lone requester is granted whatever its current rank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | N_MASTERS | Active-low requests, bit 0 = A, 1 = B, 2 = C |
| frame_n | input | 1 | Bus framing line, low while a transaction is in progress |
| irdy_n | input | 1 | Initiator-ready line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| gnt_n | output | N_MASTERS | Active-low grants, same bit order as requests |

## Verification
Two events can land on the same clock edge. One is the owner's start, seen as `frame_n` falling. The other is the owner withdrawing its request, which on its own would take the grant back. The bench provokes this by releasing the request in the same cycle that it drives `frame_n` low, both during the three-initiator sequence and in the busy-bus scenario. The start must win: the grant has to stay low through every following data phase. The rotation is then judged from the next contested arbitration, which must pick the initiator just after the old owner. The bench also checks the opposite case, a withdrawal with `frame_n` still high, and confirms that it leaves the ranking untouched.

// File: rtl/rrarb_pkg.sv
package rrarb_pkg;

    localparam int DEF_MASTERS  = 3;
    localparam int DEF_RESET_HI = 1;

    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_GRANTED = 2'd1,
        ST_OWNED   = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic idle;
        logic started;
        logic txn_end;
    } bus_sense_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rrarb_bus_watch.sv
module rrarb_bus_watch
    import rrarb_pkg::*;
(
    input  logic       frame_n,
    input  logic       irdy_n,
    input  logic       trdy_n,
    output bus_sense_t sense
);
    logic last_phase_done;

    always_comb begin
        last_phase_done = frame_n && !irdy_n && !trdy_n;
        sense.idle      = frame_n && irdy_n;
        sense.started   = !frame_n;
        sense.txn_end   = last_phase_done || (frame_n && irdy_n);
    end
endmodule

// File: rtl/rrarb_rr_pick.sv
module rrarb_rr_pick
    import rrarb_pkg::*;
#(
    parameter int N = DEF_MASTERS,
    localparam int IDX_W = idx_width(N),
    localparam int SUM_W = IDX_W + 1
) (
    input  logic [N-1:0]     req_act,
    input  logic [IDX_W-1:0] hi_idx,
    output logic             any,
    output logic [IDX_W-1:0] win_idx,
    output logic [N-1:0]     win_oh
);
    logic [2*N-1:0]   dbl;
    logic [N-1:0]     rot;
    logic [IDX_W-1:0] first;
    logic             found;
    logic [SUM_W-1:0] sum;

    always_comb begin
        dbl = {req_act, req_act};
        rot = dbl[hi_idx +: N];
    end

    always_comb begin
        first = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && rot[k]) begin
                first = IDX_W'(k);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        sum = {1'b0, hi_idx} + {1'b0, first};
        if (sum >= SUM_W'(N))
            sum = sum - SUM_W'(N);
        win_idx = sum[IDX_W-1:0];
        any     = found;
    end

    for (genvar i = 0; i < N; i++) begin : g_oh
        assign win_oh[i] = found && (win_idx == IDX_W'(i));
    end
endmodule

// File: rtl/rrarb_grant_fsm.sv
module rrarb_grant_fsm
    import rrarb_pkg::*;
#(
    parameter int N        = DEF_MASTERS,
    parameter int RESET_HI = DEF_RESET_HI,
    localparam int IDX_W = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_act,
    input  bus_sense_t       sense,
    input  logic             any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [N-1:0]     win_oh,
    output logic [IDX_W-1:0] hi_idx,
    output logic [N-1:0]     gnt_act
);
    arb_state_t       state_q;
    logic [IDX_W-1:0] owner_q;
    logic [IDX_W-1:0] hi_q;
    logic [N-1:0]     gnt_q;
    logic [IDX_W-1:0] after_owner;

    always_comb begin
        if (owner_q == IDX_W'(N - 1))
            after_owner = '0;
        else
            after_owner = owner_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            owner_q <= '0;
            hi_q    <= IDX_W'(RESET_HI);
            gnt_q   <= '0;
        end else begin
            case (state_q)
                ST_FREE: begin
                    if (any && sense.idle) begin
                        state_q <= ST_GRANTED;
                        owner_q <= win_idx;
                        gnt_q   <= win_oh;
                    end
                end
                ST_GRANTED: begin
                    if (sense.started) begin
                        state_q <= ST_OWNED;
                        hi_q    <= after_owner;
                    end else if (!req_act[owner_q]) begin
                        state_q <= ST_FREE;
                        gnt_q   <= '0;
                    end
                end
                ST_OWNED: begin
                    if (sense.txn_end) begin
                        state_q <= ST_FREE;
                        gnt_q   <= '0;
                    end
                end
                default: begin
                    state_q <= ST_FREE;
                    gnt_q   <= '0;
                end
            endcase
        end
    end

    assign hi_idx  = hi_q;
    assign gnt_act = gnt_q;
endmodule

// File: rtl/rrarb_top.sv
module rrarb_top
    import rrarb_pkg::*;
#(
    parameter int N        = DEF_MASTERS,
    parameter int RESET_HI = DEF_RESET_HI,
    localparam int IDX_W = idx_width(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_n,
    input  logic         frame_n,
    input  logic         irdy_n,
    input  logic         trdy_n,
    output logic [N-1:0] gnt_n
);
    bus_sense_t       sense;
    logic [N-1:0]     req_act;
    logic [N-1:0]     gnt_act;
    logic [N-1:0]     win_oh;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] hi_idx;
    logic             any;

    assign req_act = ~req_n;

    rrarb_bus_watch u_watch (
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .sense   (sense)
    );

    rrarb_rr_pick #(.N(N)) u_pick (
        .req_act (req_act),
        .hi_idx  (hi_idx),
        .any     (any),
        .win_idx (win_idx),
        .win_oh  (win_oh)
    );

    rrarb_grant_fsm #(.N(N), .RESET_HI(RESET_HI)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_act (req_act),
        .sense   (sense),
        .any     (any),
        .win_idx (win_idx),
        .win_oh  (win_oh),
        .hi_idx  (hi_idx),
        .gnt_act (gnt_act)
    );

    assign gnt_n = ~gnt_act;
endmodule

// File: rtl/rrarb_checker.sv
module rrarb_checker #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req_n,
    input logic         frame_n,
    input logic         irdy_n,
    input logic         trdy_n,
    input logic [N-1:0] gnt_n
);
    localparam logic [N-1:0] ALL_HI = '1;

    // R4: never two grants at once
    p_single_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~gnt_n));

    // R4: owner change passes through an all-high cycle
    p_break_make_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(gnt_n) != ALL_HI && gnt_n != ALL_HI) |-> (gnt_n == $past(gnt_n)));

    // R3: a new grant only follows an idle-bus edge
    p_grant_idle_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(gnt_n) == ALL_HI && gnt_n != ALL_HI) |-> $past(frame_n && irdy_n));

    // R5: grant held while framing is low or the target is stalling
    p_hold_txn_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_n != ALL_HI && (!frame_n || (!irdy_n && trdy_n))) |=> $stable(gnt_n));

    // R6: last data phase releases the grant
    p_release_end_r6: assert property (@(posedge clk) disable iff (rst)
        (gnt_n != ALL_HI && frame_n && !irdy_n && !trdy_n) |=> (gnt_n == ALL_HI));

    // R9: no requests and no grant keeps every grant high
    p_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(req_n) == ALL_HI && $past(gnt_n) == ALL_HI) |-> (gnt_n == ALL_HI));
endmodule

bind rrarb_top rrarb_checker #(.N(N)) u_rrarb_checker (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .trdy_n  (trdy_n),
    .gnt_n   (gnt_n)
);

// File: tb/rrarb_top_bench.sv
module rrarb_top_bench;
    localparam int NM = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] req_n = '1;
    logic          frame_n = 1'b1;
    logic          irdy_n = 1'b1;
    logic          trdy_n = 1'b1;
    logic [NM-1:0] gnt_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    rrarb_top u_rrarb_top (
        .clk     (clk),
        .rst     (rst),
        .req_n   (req_n),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .trdy_n  (trdy_n),
        .gnt_n   (gnt_n)
    );

    task automatic chk(input logic [NM-1:0] exp, input string tag);
        n_run++;
        if (gnt_n !== exp) begin
            n_fail++;
            $display("FAIL %s gnt_n actual=%b expected=%b", tag, gnt_n, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus(input logic f, input logic i, input logic t);
        frame_n = f;
        irdy_n  = i;
        trdy_n  = t;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk(3'b111, "R1 during reset");
        rst = 1'b0;
        step();
        chk(3'b111, "R1 after reset");
    endtask

    // three requesters at once, multi-phase and wait-state transactions
    task automatic t_three_way();
        req_n = 3'b000;
        step();
        chk(3'b101, "R2 B wins first");
        bus(1'b0, 1'b1, 1'b1);
        req_n = 3'b010;
        step();
        chk(3'b101, "R5 B start with req released");
        bus(1'b1, 1'b0, 1'b1);
        step();
        chk(3'b101, "R5 B target wait 1");
        step();
        chk(3'b101, "R5 B target wait 2");
        trdy_n = 1'b0;
        step();
        chk(3'b111, "R6 B released");
        bus(1'b1, 1'b1, 1'b1);
        step();
        chk(3'b011, "R7 C after B");
        bus(1'b0, 1'b1, 1'b1);
        req_n = 3'b110;
        step();
        chk(3'b011, "R5 C address phase");
        bus(1'b0, 1'b0, 1'b0);
        step();
        chk(3'b011, "R5 C first data phase");
        bus(1'b0, 1'b1, 1'b0);
        step();
        chk(3'b011, "R5 C initiator wait");
        bus(1'b1, 1'b0, 1'b0);
        step();
        chk(3'b111, "R6 C released");
        bus(1'b1, 1'b1, 1'b1);
        step();
        chk(3'b110, "R7 A granted last");
        bus(1'b0, 1'b1, 1'b1);
        req_n = 3'b111;
        step();
        chk(3'b110, "R5 A held");
        bus(1'b1, 1'b0, 1'b0);
        step();
        chk(3'b111, "R6 A released");
        bus(1'b1, 1'b1, 1'b1);
        step();
        chk(3'b111, "R9 idle 1");
        step();
        chk(3'b111, "R9 idle 2");
    endtask

    // withdrawal before start leaves the ranking alone (B, C, A)
    task automatic t_withdraw();
        req_n = 3'b011;
        step();
        chk(3'b011, "R10 lone C");
        req_n = 3'b111;
        step();
        chk(3'b111, "R8 C withdrew");
        req_n = 3'b010;
        step();
        chk(3'b011, "R8 ranking unchanged");
        req_n = 3'b110;
        step();
        chk(3'b111, "R8 C withdrew again");
        step();
        chk(3'b110, "R10 lone A");
        req_n = 3'b111;
        step();
        chk(3'b111, "R8 A withdrew");
    endtask

    // foreign traffic blocks granting; pointer survives idle time
    task automatic t_busy_bus();
        bus(1'b0, 1'b1, 1'b1);
        req_n = 3'b101;
        step();
        chk(3'b111, "R3 frame low blocks");
        bus(1'b0, 1'b0, 1'b0);
        step();
        chk(3'b111, "R3 data phase blocks");
        bus(1'b1, 1'b0, 1'b0);
        step();
        chk(3'b111, "R3 irdy low blocks");
        bus(1'b1, 1'b1, 1'b1);
        step();
        chk(3'b101, "R3 granted on idle");
        bus(1'b0, 1'b1, 1'b1);
        req_n = 3'b111;
        step();
        chk(3'b101, "R5 B held");
        bus(1'b1, 1'b0, 1'b0);
        step();
        chk(3'b111, "R6 B released");
        bus(1'b1, 1'b1, 1'b1);
        step();
        chk(3'b111, "R9 no req 1");
        step();
        chk(3'b111, "R9 no req 2");
        req_n = 3'b000;
        step();
        chk(3'b011, "R9 R7 C ranked first");
        req_n = 3'b111;
        step();
        chk(3'b111, "R8 C withdrew");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_three_way();
        t_withdraw();
        t_busy_bus();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule